// File: doc/BRIEF.md
# SDRAM Line-Fill Read Sequencer

This block fetches one 32-byte cache line from synchronous DRAM. The memory is two 16-bit devices side by side, giving a 32-bit data path, and each device has two banks. A requester presents a byte address with a one-cycle request while the block is idle. The block then opens the row, issues two burst-of-four reads and captures eight 32-bit words. It hands the words out one per cycle with a valid strobe and a beat index, and it pulses done in the precharge-wait cycle that closes the transaction.

No external multiplexer is needed between the system address and the memory. The block drives the row address, and then the column addresses, on one set of address pins using a fixed shifted mapping. The two pins below the longword boundary carry no memory address and stay low. The first read leaves the row open. The second read, issued one burst later, carries auto-precharge. It targets the other half of the line, so the data arrive back to back with no idle cycle between the two bursts. Each burst wraps inside its own aligned group of four words, so the first word returned is the one the request address names.

Top module: `sdram_line_reader`

## Requirements
- R1: While reset is held, and on the first cycle after it, busy, done and beat valid are low, the command output is NOP and every address pin is 0.
- R2: A request is taken only at a clock edge where busy is low. The cycle right after that edge shows the activate command, and busy stays high from that cycle through the done cycle and drops in the cycle after it.
- R3: The command output uses the codes 2'b00 NOP, 2'b01 activate, 2'b10 read and 2'b11 read with auto-precharge. After acceptance the order is: activate in cycle 1, read in cycle 2, read with auto-precharge in cycle 2+BURST_LEN (cycle 6 by default), and NOP in every other cycle.
- R4: In the activate cycle, address pins 13..2 carry byte-address bits 21..10, and pins 1..0 are 0.
- R5: In both read cycles, pin 13 carries address bit 21 and pins 11..10 are 0. Pin 12 is 0 with the plain read and 1 with the auto-precharge read. Pins 9..2 carry the column: address bits 9..2 for the plain read, and the same value with pin 4 inverted for the second read.
- R6: In every NOP cycle all address pins are 0, and pins 1..0 are 0 in every cycle.
- R7: The data input is sampled at the end of cycles 2+CAS_LAT through 2+CAS_LAT+7 (cycles 4..11 by default). Each sample appears on the beat data output one cycle later with beat valid high and a beat index that counts 0 to 7. Beats come out in the order the memory returns them, so with a wrapping burst of four, beat j holds word (addr[3:2]+j) mod 4 of the requested half-line for j<4, and the same position in the other half-line for j>=4.
- R8: Done is high for exactly one cycle: the precharge-wait cycle after the last data sample. In that cycle beat valid is high with index 7.
- R9: A request raised while busy is high has no effect. The transaction in progress keeps its command sequence, addresses and data, and no new activate follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Line read request, sampled only while idle |
| addr_i | input | ADDR_W | Byte address of the requested word |
| busy_o | output | 1 | High from activate through the done cycle |
| cmd_o | output | 2 | Memory command code (NOP, activate, read, read with auto-precharge) |
| apin_o | output | 2+ROW_W+BANK_W | Multiplexed row/column address pins |
| dq_i | input | DATA_W | Read data from the two devices |
| beat_vld_o | output | 1 | Beat data and index are valid |
| beat_idx_o | output | log2(2*BURST_LEN) | Position of the beat in burst order |
| beat_data_o | output | DATA_W | Captured data word |
| done_o | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench uses request addresses at word offset 0 and offset 5, plus one address with every row and column bit set. These expose a second burst that starts on the wrong half-line, or a burst that fails to wrap: the beat data would then name the wrong column. A design that puts the precharge level on the wrong read, or leaves the row address on the pins during NOP cycles, shows a mismatch on the address pins. One test raises a request while the block is busy, so a sequencer that restarts or relatches the address would issue a second activate or return words from the wrong row. Back-to-back lines check that busy drops in the cycle after done, and an off-by-one between the capture window and CAS latency would shift every beat index and datum by one cycle.

// File: rtl/sdlr_pkg.sv
package sdlr_pkg;

   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_ACTV  = 2'b01,
      CMD_READ  = 2'b10,
      CMD_READA = 2'b11
   } sdram_cmd_e;

endpackage

// File: rtl/sdlr_seq.sv
module sdlr_seq
   import sdlr_pkg::*;
#(
   parameter int AQ_W      = 20,
   parameter int CAS_LAT   = 2,
   parameter int BURST_LEN = 4,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [AQ_W-1:0]  addr_i,
   output logic             busy_o,
   output sdram_cmd_e       cmd_o,
   output logic [AQ_W-1:0]  addr_q_o,
   output logic             cap_en_o,
   output logic [IDX_W-1:0] cap_idx_o,
   output logic             done_o
);
   localparam int RD_CYC  = 2;
   localparam int RDA_CYC = RD_CYC + BURST_LEN;
   localparam int FIRST_D = RD_CYC + CAS_LAT;
   localparam int LAST_D  = FIRST_D + 2*BURST_LEN - 1;
   localparam int TPC_CYC = LAST_D + 1;
   localparam int CYC_W   = $clog2(TPC_CYC + 1);

   logic             busy_q;
   logic [CYC_W-1:0] cyc_q;
   logic [AQ_W-1:0]  addr_q;
   logic [CYC_W-1:0] rel_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cyc_q  <= '0;
         addr_q <= '0;
      end else if (!busy_q) begin
         if (req_i) begin
            busy_q <= 1'b1;
            cyc_q  <= CYC_W'(1);
            addr_q <= addr_i;
         end
      end else if (cyc_q == CYC_W'(TPC_CYC)) begin
         busy_q <= 1'b0;
         cyc_q  <= '0;
      end else begin
         cyc_q <= cyc_q + CYC_W'(1);
      end
   end

   always_comb begin
      cmd_o = CMD_NOP;
      if (busy_q) begin
         if (cyc_q == CYC_W'(1))            cmd_o = CMD_ACTV;
         else if (cyc_q == CYC_W'(RD_CYC))  cmd_o = CMD_READ;
         else if (cyc_q == CYC_W'(RDA_CYC)) cmd_o = CMD_READA;
      end
   end

   assign rel_cyc   = cyc_q - CYC_W'(FIRST_D);
   assign cap_en_o  = busy_q && (cyc_q >= CYC_W'(FIRST_D)) && (cyc_q <= CYC_W'(LAST_D));
   assign cap_idx_o = rel_cyc[IDX_W-1:0];
   assign done_o    = busy_q && (cyc_q == CYC_W'(TPC_CYC));
   assign busy_o    = busy_q;
   assign addr_q_o  = addr_q;

   AST_REQ_STARTS_ACTV: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_i) |=> (busy_o && cmd_o == CMD_ACTV)) else $error("accept"); // R2
   AST_ACTV_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_ACTV) |=> (cmd_o == CMD_READ)) else $error("actv->read"); // R3
   AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cmd_o == CMD_NOP)) else $error("idle cmd"); // R3
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!busy_o && !done_o)) else $error("done"); // R8

endmodule

// File: rtl/sdlr_addr_mux.sv
module sdlr_addr_mux
   import sdlr_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int ROW_W  = 11,
   parameter int BANK_W = 1,
   parameter int BL_LOG = 2,
   localparam int PIN_W = 2 + ROW_W + BANK_W,
   localparam int AQ_W  = COL_W + ROW_W + BANK_W
) (
   input  sdram_cmd_e       cmd_i,
   input  logic [AQ_W-1:0]  addr_q_i,
   output logic [PIN_W-1:0] apin_o
);
   localparam int AP_PIN   = 12;
   localparam int FLIP_PIN = 2 + BL_LOG;

   logic is_row, is_col, second;

   assign is_row = (cmd_i == CMD_ACTV);
   assign is_col = (cmd_i == CMD_READ) || (cmd_i == CMD_READA);
   assign second = (cmd_i == CMD_READA);

   for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      if (p < 2) begin : g_unused
         assign apin_o[p] = 1'b0;
      end else begin : g_used
         logic row_v, col_v;
         assign row_v = addr_q_i[p - 2 + COL_W];
         if (p < COL_W + 2) begin : g_col
            if (p == FLIP_PIN) begin : g_flip
               assign col_v = addr_q_i[p-2] ^ second;
            end else begin : g_keep
               assign col_v = addr_q_i[p-2];
            end
         end else if (p == AP_PIN) begin : g_ap
            assign col_v = second;
         end else if (p >= PIN_W - BANK_W) begin : g_bank
            assign col_v = row_v;
         end else begin : g_zero
            assign col_v = 1'b0;
         end
         assign apin_o[p] = is_row ? row_v : (is_col ? col_v : 1'b0);
      end
   end

endmodule

// File: rtl/sdlr_capture.sv
module sdlr_capture #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en_i,
   input  logic [IDX_W-1:0]  cap_idx_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic              beat_vld_o,
   output logic [IDX_W-1:0]  beat_idx_o,
   output logic [DATA_W-1:0] beat_data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_vld_o  <= 1'b0;
         beat_idx_o  <= '0;
         beat_data_o <= '0;
      end else begin
         beat_vld_o <= cap_en_i;
         if (cap_en_i) begin
            beat_idx_o  <= cap_idx_i;
            beat_data_o <= dq_i;
         end
      end
   end

   AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && $past(beat_vld_o)) |-> (beat_idx_o == $past(beat_idx_o) + IDX_W'(1)))
      else $error("beat order"); // R7

endmodule

// File: rtl/sdram_line_reader.sv
module sdram_line_reader
   import sdlr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int COL_W     = 8,
   parameter int ROW_W     = 11,
   parameter int BANK_W    = 1,
   parameter int BURST_LEN = 4,
   parameter int CAS_LAT   = 2,
   localparam int BL_LOG   = $clog2(BURST_LEN),
   localparam int IDX_W    = BL_LOG + 1,
   localparam int PIN_W    = 2 + ROW_W + BANK_W,
   localparam int AQ_W     = COL_W + ROW_W + BANK_W,
   localparam int USED_W   = AQ_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic [1:0]        cmd_o,
   output logic [PIN_W-1:0]  apin_o,
   input  logic [DATA_W-1:0] dq_i,
   output logic              beat_vld_o,
   output logic [IDX_W-1:0]  beat_idx_o,
   output logic [DATA_W-1:0] beat_data_o,
   output logic              done_o
);
   localparam int AP_PIN = 12;

   if (CAS_LAT < 1) begin : g_bad_cas
      $error("CAS_LAT must be at least 1");
   end
   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_bl
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if (COL_W > 10 || COL_W <= BL_LOG + 1) begin : g_bad_col
      $error("COL_W must hold a whole line and stay below the precharge pin");
   end
   if (ROW_W < 11 || BANK_W < 1) begin : g_bad_row
      $error("ROW_W must reach the precharge pin and BANK_W must be positive");
   end
   if (ADDR_W <= USED_W) begin : g_bad_addr
      $error("ADDR_W must exceed the mapped address span");
   end

   sdram_cmd_e       cmd;
   logic [AQ_W-1:0]  addr_q;
   logic             cap_en;
   logic [IDX_W-1:0] cap_idx;
   logic             unused_addr_bits;

   assign unused_addr_bits = ^{addr_i[ADDR_W-1:USED_W], addr_i[1:0]};

   sdlr_seq #(
      .AQ_W(AQ_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i[USED_W-1:2]),
      .busy_o(busy_o), .cmd_o(cmd), .addr_q_o(addr_q),
      .cap_en_o(cap_en), .cap_idx_o(cap_idx), .done_o(done_o)
   );

   sdlr_addr_mux #(
      .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .BL_LOG(BL_LOG)
   ) u_mux (
      .cmd_i(cmd), .addr_q_i(addr_q), .apin_o(apin_o)
   );

   sdlr_capture #(
      .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .cap_en_i(cap_en), .cap_idx_i(cap_idx), .dq_i(dq_i),
      .beat_vld_o(beat_vld_o), .beat_idx_o(beat_idx_o), .beat_data_o(beat_data_o)
   );

   assign cmd_o = cmd;

   AST_READ_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_READ) |-> !apin_o[AP_PIN]) else $error("read ap"); // R5
   AST_READA_CLOSES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_READA) |-> apin_o[AP_PIN]) else $error("reada ap"); // R5
   AST_NOP_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_NOP) |-> (apin_o == '0)) else $error("nop pins"); // R6
   AST_DONE_ON_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (beat_vld_o && beat_idx_o == '1)) else $error("done beat"); // R8
   AST_BEATS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      beat_vld_o |-> busy_o) else $error("beat idle"); // R7

endmodule

// File: tb/sim_sdram_line_reader.sv
`timescale 1ns/1ps
module sim_sdram_line_reader;
   localparam real CLK_NS = 8.0;
   localparam int  CL     = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [31:0] addr_i = '0;
   logic        busy_o;
   logic [1:0]  cmd_o;
   logic [13:0] apin_o;
   logic [31:0] dq_i = '0;
   logic        beat_vld_o;
   logic [2:0]  beat_idx_o;
   logic [31:0] beat_data_o;
   logic        done_o;

   int vectors = 0;
   int errs = 0;

   always #(CLK_NS/2) clk = ~clk;

   sdram_line_reader #(.CAS_LAT(CL)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
      .busy_o(busy_o), .cmd_o(cmd_o), .apin_o(apin_o), .dq_i(dq_i),
      .beat_vld_o(beat_vld_o), .beat_idx_o(beat_idx_o),
      .beat_data_o(beat_data_o), .done_o(done_o)
   );

   function automatic logic [31:0] mem_word(input logic bank, input logic [10:0] row,
                                            input logic [7:0] col);
      return {4'hC, bank, row, 8'h00, col};
   endfunction

   // cycle-based memory model: opens a row on activate, answers each read
   // with a wrapping burst of four words CL cycles after the command
   int          ncyc = 0;
   int          rd_start = -100;
   int          ra_start = -100;
   logic [7:0]  rd_col = '0, ra_col = '0;
   logic        bank_m = 1'b0;
   logic [10:0] row_m = '0;

   always @(negedge clk) begin
      ncyc = ncyc + 1;
      case (cmd_o)
         2'b01: begin bank_m = apin_o[13]; row_m = apin_o[12:2]; end
         2'b10: begin rd_start = ncyc + CL; rd_col = apin_o[9:2]; end
         2'b11: begin ra_start = ncyc + CL; ra_col = apin_o[9:2]; end
         default: ;
      endcase
      if (ncyc >= rd_start && ncyc < rd_start + 4)
         dq_i = mem_word(bank_m, row_m, {rd_col[7:2], rd_col[1:0] + 2'(ncyc - rd_start)});
      else if (ncyc >= ra_start && ncyc < ra_start + 4)
         dq_i = mem_word(bank_m, row_m, {ra_col[7:2], ra_col[1:0] + 2'(ncyc - ra_start)});
      else
         dq_i = 32'h0BAD_0BAD;
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      req_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 busy", 32'(busy_o), 0);
      chk("R1 done", 32'(done_o), 0);
      chk("R1 beat_vld", 32'(beat_vld_o), 0);
      chk("R1 cmd", 32'(cmd_o), 0);
      chk("R1 pins", 32'(apin_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after release", 32'(busy_o), 0);
      chk("R1 cmd after release", 32'(cmd_o), 0);
      chk("R1 pins after release", 32'(apin_o), 0);
   endtask

   task automatic test_idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R2 idle busy", 32'(busy_o), 0);
         chk("R6 idle cmd", 32'(cmd_o), 0);
         chk("R6 idle pins", 32'(apin_o), 0);
      end
   endtask

   // one line read; poke raises a request in the middle of it (R9)
   task automatic test_line(input logic [31:0] a, input bit poke);
      logic [7:0]  c0, c1, col;
      logic [1:0]  exp_cmd;
      logic [13:0] exp_pin;
      string       tag;
      c0 = a[9:2];
      c1 = c0 ^ 8'h04;
      @(negedge clk);
      req_i = 1'b1;
      addr_i = a;
      @(negedge clk);
      req_i = 1'b0;
      for (int k = 1; k <= 13; k++) begin
         if (k > 1) @(negedge clk);
         exp_cmd = 2'b00;
         exp_pin = '0;
         tag = "R6 nop pins";
         if (k == 1) begin
            exp_cmd = 2'b01; exp_pin = {a[21:10], 2'b00}; tag = "R4 row pins";
         end else if (k == 2) begin
            exp_cmd = 2'b10; exp_pin = {a[21], 1'b0, 2'b00, c0, 2'b00}; tag = "R5 read pins";
         end else if (k == 6) begin
            exp_cmd = 2'b11; exp_pin = {a[21], 1'b1, 2'b00, c1, 2'b00}; tag = "R5 reada pins";
         end
         chk(poke ? "R9 cmd under busy request" : "R3 cmd", 32'(cmd_o), 32'(exp_cmd));
         chk(tag, 32'(apin_o), 32'(exp_pin));
         chk("R2 busy", 32'(busy_o), 32'(k <= 12));
         chk("R8 done", 32'(done_o), 32'(k == 12));
         chk("R7 beat_vld", 32'(beat_vld_o), 32'(k >= 5 && k <= 12));
         if (k >= 5 && k <= 12) begin
            int j = k - 5;
            col = (j < 4) ? {c0[7:2], c0[1:0] + 2'(j)} : {c1[7:2], c1[1:0] + 2'(j)};
            chk("R7 beat_idx", 32'(beat_idx_o), 32'(j));
            chk(poke ? "R9 beat data" : "R7 beat data", beat_data_o,
                mem_word(a[21], a[20:10], col));
         end
         if (poke && k == 3) begin
            req_i = 1'b1;
            addr_i = ~a;
         end
         if (poke && k == 5) req_i = 1'b0;
      end
   endtask

   initial begin
      test_reset();
      test_idle(3);
      test_line(32'h0000_0000, 1'b0);
      test_idle(2);
      test_line(32'h0012_3454, 1'b0);
      test_line(32'h003F_FFFC, 1'b0);
      test_line(32'h0025_A0C8, 1'b1);
      test_idle(4);
      test_line(32'h0020_0410, 1'b0);
      test_line(32'h0001_0C2C, 1'b0);
      test_idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      errs++;
      $display("FAIL watchdog (R2): actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule